// File: doc/BRIEF.md
# Descriptor Ring Transfer Controller

This block is the front end of a descriptor-driven two-wire bus master. Software places transfer descriptors in a small ring in local memory. It then moves a head index forward and sets a run bit. The controller walks the ring from its own tail index. For each descriptor it reads the addressing, length and control word and the 64-bit buffer pointer, then starts an external transaction sequencer with those fields. When the sequencer reports completion, the controller stores the result code and the received and transmitted byte counts back into that same descriptor. It then steps the tail and raises a completion flag, an error flag, or both.

Each descriptor takes four 32-bit words of local memory, little-endian. Word 0 holds, from byte 0 up: the target address with the direction bit, the write length or command byte, the read length, and the control byte. Word 1 holds the result code, the retry byte, the received count and the transmitted count. Words 2 and 3 hold the low and high halves of the buffer pointer. Entry `n` starts at word address `4*n`. The memory port has a read latency of one cycle. Software keeps the ring size below `MAX_ENTRIES`. Bit-level bus timing happens in the sequencer, outside this block.

Top module: `dring_xfer_ctrl`

## Requirements
- R1: After reset, the control, status and timing registers read 0, the ring-size register reads `MAX_ENTRIES-1`, `irq` is low and `mem_req` is low.
- R2: Register layout, with byte offsets on `reg_addr`. Control (0x0) has run at bit 0, error-interrupt enable at bit 4 and head index at bits 23:16. Status (0x4) has busy at bit 0, error flag at bit 4, completion flag at bit 5 and tail index at bits 23:16. Ring size (0x8) holds entries minus one in bits 7:0. Timing (0xC) stores all 32 bits. Control, ring size and timing read back what was written.
- R3: While run is set and tail differs from head, the block reads words 0, 2 and 3 of the entry at the tail, in that order. It then asserts `seq_start` for one cycle, with `seq_desc` equal to word 0 and `seq_dptr` equal to {word 3, word 2}. This happens in the cycle after the fifth clock edge that follows the edge taking the run write.
- R4: On `seq_done`, the block writes word 1 of that entry with byte enables 4'b1101. Byte 0 gets `seq_status`, byte 2 gets `seq_rx` and byte 3 gets `seq_tx`. The retry byte (byte 1) keeps its stored value.
- R5: After each write-back the tail moves to the next entry. After the entry equal to the ring-size value, it wraps to 0.
- R6: The status busy bit is high while a descriptor is in flight, or while run is set and tail differs from head. It reads low once the tail equals the head.
- R7: The completion flag is set when a descriptor whose control byte has bit 6 set completes. Descriptors without that bit leave the flag unchanged.
- R8: A completion whose result code has bit 0 (success) clear sets the error flag, but only while error-interrupt enable is set.
- R9: If an errored descriptor has control bit 7 set, the run bit is cleared. No further descriptors are fetched until software sets run again.
- R10: Writing 1 to status bit 4 or bit 5 clears that flag. Writing 0 leaves it unchanged.
- R11: `irq` equals completion flag OR (error flag AND error-interrupt enable).
- R12: `spd_sel` carries timing bits 31:30, with the encoding 0 = 80 kHz, 1 = 100 kHz, 2 = 400 kHz, 3 = 1 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor memory access request |
| mem_we | output | 1 | Descriptor memory write |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | MEM_AW | Descriptor memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_desc | output | 32 | Descriptor word 0 for the sequencer |
| seq_dptr | output | 64 | Buffer pointer for the sequencer |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_status | input | 8 | Result code from the sequencer |
| seq_rx | input | 8 | Bytes received |
| seq_tx | input | 8 | Bytes transmitted |
| spd_sel | output | 2 | Bus speed selection |
| irq | output | 1 | Interrupt request level |

## Verification
Register reads are combinational, and a register write takes effect at the edge that samples it. The first `seq_start` appears exactly five edges after the run write. The bench samples at falling edges and checks for low one cycle before that point and high at it. Write-back happens one cycle after `seq_done`, and tail, flags and `irq` settle at the next edge. For those results the bench polls the busy bit on falling edges until it drops, then compares memory and registers. Because the run write lands at a known edge, the polling cannot miss the start of the work.

// File: rtl/dring_pkg.sv
// dring_pkg: shared constants and types for the descriptor ring controller.
// Assumes 32-bit registers and four-word descriptors.
package dring_pkg;
    localparam int PTR_W = 8;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_SIZE = 4'h8;
    localparam logic [3:0] OFS_TIME = 4'hC;

    localparam int B_RUN   = 0;
    localparam int B_ERREN = 4;
    localparam int B_ERRF  = 4;
    localparam int B_DONEF = 5;
    localparam int B_PTR_LO = 16;

    // control byte lives in bits 31:24 of descriptor word 0
    localparam int D_IRQREQ = 24 + 6;
    localparam int D_HALTERR = 24 + 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD0, ST_RD2, ST_RD3, ST_CAP, ST_GO, ST_WAIT, ST_WB
    } eng_state_t;
endpackage

// File: rtl/dring_csr.sv
// dring_csr: control, status, ring-size and timing registers plus
// interrupt flags. Assumes the engine pulses its events for one cycle.
module dring_csr
    import dring_pkg::*;
#(
    parameter int REG_AW      = 4,
    parameter int MAX_ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PTR_W-1:0]  tail,
    input  logic              in_prog,
    input  logic              ev_done,
    input  logic              ev_err,
    input  logic              clr_start,
    output logic              run,
    output logic              err_en,
    output logic [PTR_W-1:0]  head,
    output logic [PTR_W-1:0]  size_m1,
    output logic [1:0]        spd_sel,
    output logic              irq
);
    localparam logic [PTR_W-1:0] SIZE_RST = PTR_W'(MAX_ENTRIES - 1);

    logic        run_q, erren_q, donef_q, errf_q;
    logic [PTR_W-1:0] head_q, size_q;
    logic [31:0] time_q;
    logic        wr_ctrl, wr_stat, wr_size, wr_time;

    // decode of which register a write targets
    always_comb begin
        wr_ctrl = reg_we && (reg_addr[3:0] == OFS_CTRL);
        wr_stat = reg_we && (reg_addr[3:0] == OFS_STAT);
        wr_size = reg_we && (reg_addr[3:0] == OFS_SIZE);
        wr_time = reg_we && (reg_addr[3:0] == OFS_TIME);
    end

    // control register; a software write outranks a halt-on-error clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            erren_q <= 1'b0;
            head_q  <= '0;
        end else begin
            if (clr_start) run_q <= 1'b0;
            if (wr_ctrl) begin
                run_q   <= reg_wdata[B_RUN];
                erren_q <= reg_wdata[B_ERREN];
                head_q  <= reg_wdata[B_PTR_LO +: PTR_W];
            end
        end
    end

    // ring size and timing storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SIZE_RST;
            time_q <= '0;
        end else begin
            if (wr_size) size_q <= reg_wdata[PTR_W-1:0];
            if (wr_time) time_q <= reg_wdata;
        end
    end

    // sticky flags: set by events, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            donef_q <= 1'b0;
            errf_q  <= 1'b0;
        end else begin
            donef_q <= (donef_q && !(wr_stat && reg_wdata[B_DONEF])) || ev_done;
            errf_q  <= (errf_q && !(wr_stat && reg_wdata[B_ERRF])) || (ev_err && erren_q);
        end
    end

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr[3:0])
            OFS_CTRL: begin
                reg_rdata[B_RUN]   = run_q;
                reg_rdata[B_ERREN] = erren_q;
                reg_rdata[B_PTR_LO +: PTR_W] = head_q;
            end
            OFS_STAT: begin
                reg_rdata[0]       = in_prog;
                reg_rdata[B_ERRF]  = errf_q;
                reg_rdata[B_DONEF] = donef_q;
                reg_rdata[B_PTR_LO +: PTR_W] = tail;
            end
            OFS_SIZE: reg_rdata[PTR_W-1:0] = size_q;
            OFS_TIME: reg_rdata = time_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign run     = run_q;
    assign err_en  = erren_q;
    assign head    = head_q;
    assign size_m1 = size_q;
    assign spd_sel = time_q[31:30];
    assign irq     = donef_q || (errf_q && erren_q);

    // completion event always leaves the flag set
    p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> donef_q);
    // error flag only rises while enable was set
    p_err_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(errf_q) |-> $past(erren_q));
    // write-one clears the completion flag when no event competes
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[B_DONEF] && !ev_done) |=> !donef_q);
    // irq never high with both flags clear
    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (donef_q || errf_q));
endmodule

// File: rtl/dring_engine.sv
// dring_engine: walks the ring from tail to head, fetches descriptor words
// 0, 2 and 3, launches the sequencer, writes results into word 1.
// Assumes memory read data one cycle after the request.
module dring_engine
    import dring_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PTR_W-1:0]  head,
    input  logic [PTR_W-1:0]  size_m1,
    output logic              mem_req,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              seq_start,
    output logic [31:0]       seq_desc,
    output logic [63:0]       seq_dptr,
    input  logic              seq_done,
    input  logic [7:0]        seq_status,
    input  logic [7:0]        seq_rx,
    input  logic [7:0]        seq_tx,
    output logic [PTR_W-1:0]  tail,
    output logic              in_prog,
    output logic              ev_done,
    output logic              ev_err,
    output logic              clr_start
);
    localparam int IDX_W = MEM_AW - 2;

    eng_state_t       st_q, st_d;
    logic [PTR_W-1:0] tail_q, tail_nx;
    logic [31:0]      w0_q, w2_q, w3_q;
    logic [7:0]       rst_q, rrx_q, rtx_q;
    logic             pending;
    logic [1:0]       word_sel;

    assign pending = run && (tail_q != head);
    assign tail_nx = (tail_q == size_m1) ? '0 : tail_q + PTR_W'(1);

    // next-state selection
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (pending) st_d = ST_RD0;
            ST_RD0:  st_d = ST_RD2;
            ST_RD2:  st_d = ST_RD3;
            ST_RD3:  st_d = ST_CAP;
            ST_CAP:  st_d = ST_GO;
            ST_GO:   st_d = ST_WAIT;
            ST_WAIT: if (seq_done) st_d = ST_WB;
            ST_WB:   st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state, tail and captured descriptor fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            tail_q <= '0;
            w0_q   <= '0;
            w2_q   <= '0;
            w3_q   <= '0;
            rst_q  <= '0;
            rrx_q  <= '0;
            rtx_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_RD2) w0_q <= mem_rdata;
            if (st_q == ST_RD3) w2_q <= mem_rdata;
            if (st_q == ST_CAP) w3_q <= mem_rdata;
            if (st_q == ST_WAIT && seq_done) begin
                rst_q <= seq_status;
                rrx_q <= seq_rx;
                rtx_q <= seq_tx;
            end
            if (st_q == ST_WB) tail_q <= tail_nx;
        end
    end

    // word offset within the descriptor for each memory state
    always_comb begin
        case (st_q)
            ST_RD2:  word_sel = 2'd2;
            ST_RD3:  word_sel = 2'd3;
            ST_WB:   word_sel = 2'd1;
            default: word_sel = 2'd0;
        endcase
    end

    assign mem_req   = (st_q == ST_RD0) || (st_q == ST_RD2) ||
                       (st_q == ST_RD3) || (st_q == ST_WB);
    assign mem_we    = (st_q == ST_WB);
    assign mem_be    = (st_q == ST_WB) ? 4'b1101 : 4'b0000;
    assign mem_addr  = {tail_q[IDX_W-1:0], word_sel};
    assign mem_wdata = {rtx_q, rrx_q, 8'h00, rst_q};

    assign seq_start = (st_q == ST_GO);
    assign seq_desc  = w0_q;
    assign seq_dptr  = {w3_q, w2_q};

    assign tail      = tail_q;
    assign in_prog   = (st_q != ST_IDLE) || pending;
    assign ev_done   = (st_q == ST_WB) && w0_q[D_IRQREQ];
    assign ev_err    = (st_q == ST_WB) && !rst_q[0];
    assign clr_start = ev_err && w0_q[D_HALTERR];

    // word 0 read is always followed by word 2 read
    p_fetch_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_addr[1:0] == 2'd0) |=> (mem_req && mem_addr[1:0] == 2'd2));
    // start is a single-cycle pulse
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);
    // write-back targets word 1 with retry byte masked
    p_wb_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && mem_addr[1:0] == 2'd1 && mem_be == 4'b1101));
    // tail only steps by one with wrap
    p_tail_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q != $past(tail_q)) |->
        (tail_q == (($past(tail_q) == $past(size_m1)) ? '0 : $past(tail_q) + PTR_W'(1))));
    // no memory traffic while not busy
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_prog |-> !mem_req);
endmodule

// File: rtl/dring_xfer_ctrl.sv
// dring_xfer_ctrl: top of the descriptor ring transfer controller.
// Joins the register block and the ring engine. Assumes the ring starts at
// word address 0 and software keeps the ring size below MAX_ENTRIES.
module dring_xfer_ctrl
    import dring_pkg::*;
#(
    parameter int MAX_ENTRIES = 16,
    parameter int REG_AW      = 4,
    parameter int MEM_AW      = $clog2(MAX_ENTRIES) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              seq_start,
    output logic [31:0]       seq_desc,
    output logic [63:0]       seq_dptr,
    input  logic              seq_done,
    input  logic [7:0]        seq_status,
    input  logic [7:0]        seq_rx,
    input  logic [7:0]        seq_tx,
    output logic [1:0]        spd_sel,
    output logic              irq
);
    logic [PTR_W-1:0] tail, head, size_m1;
    logic run, err_en, in_prog, ev_done, ev_err, clr_start;

    dring_csr #(.REG_AW(REG_AW), .MAX_ENTRIES(MAX_ENTRIES)) u_csr (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .tail, .in_prog, .ev_done, .ev_err, .clr_start,
        .run, .err_en, .head, .size_m1, .spd_sel, .irq
    );

    dring_engine #(.MEM_AW(MEM_AW)) u_eng (
        .clk, .rst_n, .run, .head, .size_m1,
        .mem_req, .mem_we, .mem_be, .mem_addr, .mem_wdata, .mem_rdata,
        .seq_start, .seq_desc, .seq_dptr, .seq_done,
        .seq_status, .seq_rx, .seq_tx,
        .tail, .in_prog, .ev_done, .ev_err, .clr_start
    );

    // halt request only accompanies an error event
    p_halt_needs_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_start |-> ev_err);
endmodule

// File: tb/dring_xfer_ctrl_tb_top.sv
// Directed bench: memory and sequencer models, one task per scenario.
module dring_xfer_ctrl_tb_top;
    localparam int MAXE = 16;
    localparam int MAW  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [3:0]  mem_be;
    logic [MAW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        seq_start;
    logic [31:0] seq_desc;
    logic [63:0] seq_dptr;
    logic        seq_done = 1'b0;
    logic [7:0]  seq_status = 8'h01, seq_rx = '0, seq_tx = '0;
    logic [1:0]  spd_sel;
    logic        irq;

    logic [31:0] mem [0:63];
    int          cnt = 0;
    int          launches = 0;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    dring_xfer_ctrl dut_i (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .mem_req, .mem_we, .mem_be, .mem_addr, .mem_wdata, .mem_rdata,
        .seq_start, .seq_desc, .seq_dptr, .seq_done,
        .seq_status, .seq_rx, .seq_tx, .spd_sel, .irq
    );

    // descriptor memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    // sequencer model: completes three cycles after start
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0;
            seq_done <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            if (seq_start) begin
                cnt <= 3;
                launches <= launches + 1;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) seq_done <= 1'b1;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic put_desc(input int e, input logic [7:0] ctl, input logic [63:0] dp);
        mem[e*4+0] = {ctl, 8'h04, 8'h02, 8'h50 + 8'(e)};
        mem[e*4+1] = {8'h00, 8'h00, 8'hA5, 8'h00};
        mem[e*4+2] = dp[31:0];
        mem[e*4+3] = dp[63:32];
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            rd(4'h4, s);
            guard++;
        end while (s[0] && guard < 500);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); chk("R1 ctrl", v, 0);
        rd(4'h4, v); chk("R1 stat", v, 0);
        rd(4'h8, v); chk("R1 size", v, 32'h0F);
        rd(4'hC, v); chk("R1 time", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_req", mem_req, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(4'h8, 32'h3);
        rd(4'h8, v); chk("R2 size", v, 32'h3);
        wr(4'h0, 32'h0000_0010);
        rd(4'h0, v); chk("R2 ctrl", v, 32'h0000_0010);
        wr(4'h0, 32'h0000_0000);
        wr(4'hC, 32'h8000_1234);
        rd(4'hC, v); chk("R2 time", v, 32'h8000_1234);
        chk("R12 400k", spd_sel, 2'd2);
        wr(4'hC, 32'hC000_0000);
        chk("R12 1M", spd_sel, 2'd3);
        wr(4'hC, 32'h4000_0000);
        chk("R12 100k", spd_sel, 2'd1);
    endtask

    task automatic t_single();
        logic [31:0] v;
        int l0;
        put_desc(0, 8'h40, 64'h1111_2222_3333_4444);
        seq_status = 8'h01; seq_rx = 8'h05; seq_tx = 8'h02;
        l0 = launches;
        wr(4'h0, 32'h0001_0001);
        repeat (4) @(negedge clk);
        chk("R3 no early start", seq_start, 0);
        @(negedge clk);
        chk("R3 start timing", seq_start, 1);
        chk("R3 desc", seq_desc, mem[0]);
        chk("R3 dptr", seq_dptr, 64'h1111_2222_3333_4444);
        wait_idle();
        chk("R4 writeback", mem[1], {8'h02, 8'h05, 8'hA5, 8'h01});
        rd(4'h4, v);
        chk("R5 tail", v[23:16], 8'd1);
        chk("R6 idle", v[0], 0);
        chk("R7 done flag", v[5], 1);
        chk("R11 irq done", irq, 1);
        chk("R3 one launch", launches - l0, 1);
        wr(4'h4, 32'h0000_0000);
        rd(4'h4, v); chk("R10 zero keeps", v[5], 1);
        wr(4'h4, 32'h0000_0020);
        rd(4'h4, v); chk("R10 clear", v[5], 0);
        chk("R11 irq low", irq, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        int l0;
        for (int e = 1; e < 4; e++) put_desc(e, 8'h00, 64'(e));
        seq_status = 8'h01; seq_rx = 8'h07; seq_tx = 8'h01;
        l0 = launches;
        wr(4'h0, 32'h0000_0001);
        @(negedge clk);
        rd(4'h4, v); chk("R6 busy", v[0], 1);
        wait_idle();
        rd(4'h4, v);
        chk("R5 wrap tail", v[23:16], 8'd0);
        chk("R5 launches", launches - l0, 3);
        chk("R7 no irq req", v[5], 0);
        chk("R4 entry3", mem[13], {8'h01, 8'h07, 8'hA5, 8'h01});
    endtask

    task automatic t_err_masked();
        logic [31:0] v;
        put_desc(0, 8'h00, 64'h0);
        seq_status = 8'h08;
        wr(4'h0, 32'h0001_0001);
        wait_idle();
        rd(4'h4, v);
        chk("R8 masked flag", v[4], 0);
        chk("R8 masked irq", irq, 0);
        chk("R5 tail1", v[23:16], 8'd1);
    endtask

    task automatic t_err_enabled();
        logic [31:0] v;
        put_desc(1, 8'h00, 64'h0);
        seq_status = 8'h10;
        wr(4'h0, 32'h0002_0011);
        wait_idle();
        rd(4'h4, v);
        chk("R8 err flag", v[4], 1);
        chk("R11 irq err", irq, 1);
        wr(4'h0, 32'h0002_0001);
        chk("R11 masked by enable", irq, 0);
        rd(4'h4, v); chk("R11 flag kept", v[4], 1);
        wr(4'h4, 32'h0000_0010);
        rd(4'h4, v); chk("R10 err clear", v[4], 0);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        int l0;
        put_desc(2, 8'h80, 64'h0);
        put_desc(3, 8'h00, 64'h0);
        seq_status = 8'h40;
        l0 = launches;
        wr(4'h0, 32'h0000_0011);
        wait_idle();
        repeat (10) @(negedge clk);
        rd(4'h0, v); chk("R9 run cleared", v[0], 0);
        rd(4'h4, v); chk("R9 tail stop", v[23:16], 8'd3);
        chk("R9 one launch", launches - l0, 1);
        chk("R8 err set", v[4], 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_single();
        t_wrap();
        t_err_masked();
        t_err_enabled();
        t_halt();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule